// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a MAC receive path and decides, once per frame, whether the frame should be kept. The first six bytes of the frame (the destination address) arrive one per clock on a byte stream. A start-of-frame flag marks the first byte. A 1 on the valid input marks each cycle that carries a byte. After the sixth address byte, the block reports a single keep/drop verdict.

There are four ways for a frame to be kept:
- its destination equals the programmed station address;
- it is the all-ones broadcast address;
- promiscuous operation is enabled;
- a 64-bit hash table has the bit set that the address selects.

The hash table used depends on the address type. Unicast addresses use the individual table and multicast addresses use the group table. The hash is a reflected CRC-32 built incrementally while the bytes arrive.

Configuration is written through a small register port into shadow registers. A snapshot of the shadow registers is taken when a frame starts, so a write during a frame only affects later frames.

The control sequencer has three states:
- `ST_IDLE`: after reset.
- `ST_ADDR`: collecting address bytes.
- `ST_TAIL`: the verdict is given and the rest of the frame is ignored.

It has three transitions:
- `START` goes from any state to `ST_ADDR` on a valid byte that carries the start-of-frame flag.
- `ADDR_DONE` goes from `ST_ADDR` to `ST_TAIL` when the sixth address byte is taken.
- `HOLD` keeps the current state in all other cycles.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `flt_valid` and `flt_accept` are low. The station address, both hash tables and the promiscuous bit are all zero.
- R2: The hash index is computed as follows.
  - Start the CRC at 0xFFFFFFFF.
  - Feed each of the six address bytes, in arrival order, least-significant bit first.
  - For each bit: if (crc ^ bit) & 1, the new crc is (crc >> 1) ^ 0xEDB88320; otherwise it is crc >> 1.
  - The index is crc[31:26].
  - An index below 32 selects that bit of the table's low word. An index of 32 or more selects bit (index-32) of the high word.
  - A set bit accepts the frame.
- R3: Bit 0 of the first address byte selects the table. A 1 selects the group table and a 0 selects the individual table. A bit set only in the other table does not accept the frame.
- R4: A destination equal to the station address is accepted with all tables zero.
  - Select 0 writes address bytes 1 to 4, with byte 1 in bits 31:24.
  - Select 1 bits 31:16 hold bytes 5 and 6, with byte 5 in bits 31:24.
  - Byte 1 is the byte that arrives first.
- R5: The address FF-FF-FF-FF-FF-FF is accepted with all tables zero and promiscuous mode off.
- R6: Bit 0 written at select 6 is the promiscuous bit. When it is 1, every frame is accepted.
- R7: `flt_valid` is a one-cycle pulse on the clock after the clock that takes the sixth address byte. `flt_accept` is meaningful only with it and is low in every other cycle.
- R8: The following bytes change nothing:
  - bytes after the sixth;
  - cycles with `rx_valid` low, which only delay the verdict.

  A new start-of-frame byte before the sixth byte abandons the partial address, and no verdict is given for it.
- R9: Register writes are held in shadow registers. A frame uses the values present when its start byte is taken, so a write during a frame affects only the next frame.
- R10: The table registers are at these selects:
  - 2 and 3: individual table, low and high word.
  - 4 and 5: group table, low and high word.

  Select 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select |
| cfg_wr_data | input | 32 | Register write data |
| rx_sof | input | 1 | Marks the first address byte (qualified by rx_valid) |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Frame byte |
| flt_valid | output | 1 | Verdict strobe |
| flt_accept | output | 1 | Keep the frame (valid with flt_valid) |

## Verification
A verdict is due exactly one clock after the clock edge that takes the sixth address byte. The bench drives each byte after a falling edge. It samples at the falling edge that follows the edge taking the sixth byte and expects the strobe and the verdict there. At every other falling edge within a frame, including idle gaps, tail bytes and abandoned partial addresses, it expects the strobe low.

Configuration writes take no visible effect until the next start byte. The bench therefore keeps its own shadow model and snapshots it when it drives a start byte. Expected verdicts come from that snapshot and from a CRC computed bit by bit in the bench.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
    localparam int unsigned MAC_BYTES = 6;
    localparam int unsigned MAC_W     = MAC_BYTES * 8;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned HASH_W    = 6;
    localparam int unsigned TBL_W     = 1 << HASH_W;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned CNT_W     = $clog2(MAC_BYTES + 1);
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_TAIL = 2'd2
    } fsm_t;

    localparam logic [SEL_W-1:0] SEL_STA_LO = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STA_HI = 3'd1;
    localparam logic [SEL_W-1:0] SEL_IND_LO = 3'd2;
    localparam logic [SEL_W-1:0] SEL_IND_HI = 3'd3;
    localparam logic [SEL_W-1:0] SEL_GRP_LO = 3'd4;
    localparam logic [SEL_W-1:0] SEL_GRP_HI = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd6;

    typedef struct packed {
        logic [MAC_W-1:0] station;
        logic [TBL_W-1:0] ind_tbl;
        logic [TBL_W-1:0] grp_tbl;
        logic             promisc;
    } filt_cfg_t;

    // One byte through the reflected CRC, low bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/rx_filt_cfg.sv
module rx_filt_cfg
    import rx_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             load,
    output filt_cfg_t        active
);
    localparam int unsigned HALF = TBL_W / 2;
    localparam int unsigned STA_LO_W = REG_W;
    localparam int unsigned STA_HI_W = MAC_W - REG_W;

    filt_cfg_t shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_STA_LO: shadow.station[MAC_W-1 -: STA_LO_W] <= wr_data;
                SEL_STA_HI: shadow.station[STA_HI_W-1:0] <= wr_data[REG_W-1 -: STA_HI_W];
                SEL_IND_LO: shadow.ind_tbl[HALF-1:0]     <= wr_data;
                SEL_IND_HI: shadow.ind_tbl[TBL_W-1:HALF] <= wr_data;
                SEL_GRP_LO: shadow.grp_tbl[HALF-1:0]     <= wr_data;
                SEL_GRP_HI: shadow.grp_tbl[TBL_W-1:HALF] <= wr_data;
                SEL_CTRL:   shadow.promisc <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Snapshot taken on the start byte of each frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= shadow;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active)) else $error("active config changed mid-frame"); // R9
endmodule

// File: rtl/rx_filt_hash.sv
module rx_filt_hash
    import rx_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [7:0]        data,
    output logic [HASH_W-1:0] index
);
    logic [31:0] crc_q;
    logic [31:0] crc_base;
    logic [31:0] crc_nxt;

    always_comb begin
        crc_base = restart ? CRC_SEED : crc_q;
        crc_nxt  = crc_byte(crc_base, data);
        index    = crc_nxt[31 -: HASH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                crc_q <= CRC_SEED;
        else if (restart || step)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/rx_filt_match.sv
module rx_filt_match
    import rx_filt_pkg::*;
(
    input  filt_cfg_t         cfg,
    input  logic [MAC_W-1:0]  dest,
    input  logic [HASH_W-1:0] index,
    output logic              accept
);
    localparam int unsigned GROUP_BIT = MAC_W - 8;

    logic             is_group;
    logic [TBL_W-1:0] tbl;
    logic             exact, bcast, hit;

    always_comb begin
        is_group = dest[GROUP_BIT];
        tbl      = is_group ? cfg.grp_tbl : cfg.ind_tbl;
        hit      = tbl[index];
        exact    = (dest == cfg.station);
        bcast    = &dest;
        accept   = cfg.promisc | exact | bcast | hit;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_filt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_sel,
    input  logic [31:0] cfg_wr_data,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        flt_valid,
    output logic        flt_accept
);
    localparam int unsigned SR_W = MAC_W - 8;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAC_BYTES - 1);

    fsm_t              state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [SR_W-1:0]   addr_sr;
    logic              start, take, last;
    logic [HASH_W-1:0] hash_idx;
    logic              match_ok;
    filt_cfg_t         cfg_act;

    assign start = rx_valid & rx_sof;
    assign take  = rx_valid & (rx_sof | (state == ST_ADDR));
    assign last  = rx_valid & ~rx_sof & (state == ST_ADDR) & (cnt == LAST_CNT);

    rx_filt_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .load    (start),
        .active  (cfg_act)
    );

    rx_filt_hash u_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .step    (take),
        .data    (rx_byte),
        .index   (hash_idx)
    );

    rx_filt_match u_match (
        .cfg    (cfg_act),
        .dest   ({addr_sr, rx_byte}),
        .index  (hash_idx),
        .accept (match_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: START, ADDR_DONE, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_ADDR;
            ST_ADDR: begin
                if (start)     state_nxt = ST_ADDR;
                else if (last) state_nxt = ST_TAIL;
            end
            ST_TAIL: if (start) state_nxt = ST_ADDR;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Address collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            addr_sr <= '0;
        end else if (start) begin
            cnt     <= CNT_W'(1);
            addr_sr <= {{(SR_W-8){1'b0}}, rx_byte};
        end else if (take) begin
            cnt     <= cnt + CNT_W'(1);
            addr_sr <= {addr_sr[SR_W-9:0], rx_byte};
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_valid  <= 1'b0;
            flt_accept <= 1'b0;
        end else begin
            flt_valid  <= last;
            flt_accept <= last & match_ok;
        end
    end

    AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid) else $error("verdict strobe longer than one cycle"); // R7
    AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |-> !flt_accept) else $error("accept without strobe"); // R7
    AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cfg_act.promisc) |=> flt_accept) else $error("promiscuous frame dropped"); // R6
    AST_BCAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (last && (&{addr_sr, rx_byte})) |=> flt_accept) else $error("broadcast dropped"); // R5
    AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && !start) |=> !flt_valid) else $error("verdict from tail byte"); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAC_BYTES)) else $error("byte counter overran"); // R8
endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        flt_valid;
    logic        flt_accept;

    int checks = 0;
    int failures = 0;

    // bench shadow model of configuration
    logic [47:0] m_sta = '0;
    logic [63:0] m_ind = '0, m_grp = '0;
    logic        m_pro = 1'b0;

    always #2.5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .flt_valid(flt_valid), .flt_accept(flt_accept)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ a[47 - 8*b - 7 + k];
                c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_wr(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: m_sta[47:16] = d;
            3'd1: m_sta[15:0]  = d[31:16];
            3'd2: m_ind[31:0]  = d;
            3'd3: m_ind[63:32] = d;
            3'd4: m_grp[31:0]  = d;
            3'd5: m_grp[63:32] = d;
            3'd6: m_pro        = d[0];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        model_wr(sel, d);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_tables(input logic [63:0] ind, input logic [63:0] grp);
        wr(3'd2, ind[31:0]); wr(3'd3, ind[63:32]);
        wr(3'd4, grp[31:0]); wr(3'd5, grp[63:32]);
    endtask

    function automatic logic expect_acc(input logic [47:0] a, input logic [47:0] s,
                                        input logic [63:0] ti, input logic [63:0] tg, input logic p);
        logic [63:0] t;
        t = a[40] ? tg : ti;
        return p | (a == s) | (&a) | t[ref_idx(a)];
    endfunction

    // Sends six address bytes, optional idle gaps, optional mid-frame write, tail bytes.
    task automatic send_frame(input logic [47:0] a, input bit gaps, input int extra,
                              input bit mid_wr, input logic [2:0] wsel, input logic [31:0] wdat,
                              input string req);
        logic [47:0] s; logic [63:0] ti, tg; logic p; logic e;
        s = m_sta; ti = m_ind; tg = m_grp; p = m_pro;
        e = expect_acc(a, s, ti, tg, p);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[47 - 8*i -: 8];
            if (mid_wr && i == 2) begin
                cfg_wr_en = 1'b1; cfg_wr_sel = wsel; cfg_wr_data = wdat; model_wr(wsel, wdat);
            end
            @(negedge clk);
            cfg_wr_en = 1'b0;
            if (i < 5) chk({req, " R7 no early strobe"}, {31'b0, flt_valid}, 32'd0);
            if (gaps && i < 5) begin
                rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = 8'hFF;
                @(negedge clk);
                chk("R8 gap no strobe", {31'b0, flt_valid}, 32'd0);
            end
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk({req, " R7 strobe"}, {31'b0, flt_valid}, 32'd1);
        chk({req, " verdict"}, {31'b0, flt_accept}, {31'b0, e});
        for (int x = 0; x < extra; x++) begin
            rx_valid = 1'b1; rx_byte = 8'(x * 29 + 3);
            @(negedge clk);
            chk("R8 tail byte no strobe", {30'b0, flt_valid, flt_accept}, 32'd0);
        end
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R7 strobe one cycle", {30'b0, flt_valid, flt_accept}, 32'd0);
    endtask

    function automatic logic [47:0] gen_addr(input int n, input bit grp);
        logic [7:0] b0;
        b0 = (8'(n * 13 + 6) & 8'hFE) | {7'b0, grp};
        return {b0, 40'(n) * 40'h1F3A5C7D9B + 40'h0102030405};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [47:0] a, b;
        logic [5:0] ix;
        logic [63:0] one;
        repeat (3) @(negedge clk);
        chk("R1 reset strobe", {31'b0, flt_valid}, 32'd0);
        chk("R1 reset accept", {31'b0, flt_accept}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset config is all zero -> unicast unknown rejected, hash off
        send_frame(48'h0A_11_22_33_44_55, 0, 0, 0, 3'd0, 0, "R1 zero config");
        chk("R1 reject after reset", {31'b0, expect_acc(48'h0A_11_22_33_44_55, 0, 0, 0, 0)}, 32'd0);

        // R5 broadcast
        send_frame(48'hFFFF_FFFF_FFFF, 0, 2, 0, 3'd0, 0, "R5 broadcast");

        // R4 station exact match
        wr(3'd0, 32'h0200_5E10); wr(3'd1, 32'hA5C3_0000);
        send_frame(48'h0200_5E10_A5C3, 0, 0, 0, 3'd0, 0, "R4 station match");
        send_frame(48'h0200_5E10_A5C2, 0, 0, 0, 3'd0, 0, "R4 station mismatch");
        send_frame(48'h0300_5E10_A5C3, 0, 0, 0, 3'd0, 0, "R4 first byte differs");

        // R2/R3/R10 hash sweep over unicast and multicast addresses
        for (int n = 0; n < 96; n++) begin
            for (int g = 0; g < 2; g++) begin
                a = gen_addr(n, g[0]);
                ix = ref_idx(a);
                one = 64'd1 << ix;
                if (g == 0) set_tables(one, 64'd0); else set_tables(64'd0, one);
                send_frame(a, 0, 0, 0, 3'd0, 0, "R2 own bit set");
                if (g == 0) set_tables(64'd0, one); else set_tables(one, 64'd0);
                send_frame(a, 0, 0, 0, 3'd0, 0, "R3 other table only");
                if (g == 0) set_tables(~one, 64'd0); else set_tables(64'd0, ~one);
                send_frame(a, 0, 0, 0, 3'd0, 0, "R2 all but own bit");
            end
        end
        set_tables(64'd0, 64'd0);

        // R10 select 7 ignored
        wr(3'd7, 32'hFFFF_FFFF);
        send_frame(48'h0A_11_22_33_44_55, 0, 0, 0, 3'd0, 0, "R10 sel7 ignored");

        // R6 promiscuous
        wr(3'd6, 32'd1);
        send_frame(48'h0A_11_22_33_44_55, 0, 0, 0, 3'd0, 0, "R6 promisc unicast");
        send_frame(48'h0B_99_88_77_66_55, 0, 0, 0, 3'd0, 0, "R6 promisc multicast");
        wr(3'd6, 32'd0);
        send_frame(48'h0A_11_22_33_44_55, 0, 0, 0, 3'd0, 0, "R6 promisc off");

        // R8 idle gaps and tail bytes
        send_frame(48'h0200_5E10_A5C3, 1, 5, 0, 3'd0, 0, "R8 gaps station");
        send_frame(48'h0A00_5E10_A5C3, 1, 3, 0, 3'd0, 0, "R8 gaps other");

        // R8 restart: partial address abandoned
        b = 48'h0200_5E10_A5C3;
        for (int i = 0; i < 4; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = b[47 - 8*i -: 8];
            @(negedge clk);
            chk("R8 partial no strobe", {31'b0, flt_valid}, 32'd0);
        end
        send_frame(48'h0A_11_22_33_44_55, 0, 0, 0, 3'd0, 0, "R8 restart new frame");

        // R9 mid-frame write applies from next frame
        send_frame(48'h0200_5E10_A5C3, 0, 0, 1, 3'd0, 32'h0A11_2233, "R9 old station during write");
        wr(3'd1, 32'h4455_0000);
        send_frame(48'h0200_5E10_A5C3, 0, 0, 0, 3'd0, 0, "R9 old station gone");
        send_frame(48'h0A11_2233_4455, 0, 0, 0, 3'd0, 0, "R9 new station");
        send_frame(48'h0A11_2233_4455, 0, 0, 1, 3'd6, 32'd1, "R9 promisc write mid-frame");
        send_frame(48'h0C00_0000_0001, 0, 0, 0, 3'd0, 0, "R9 promisc next frame");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule